// File: doc/BRIEF.md
# Interrupt destination bitmask generator

This block turns one interrupt message into the set of agents that must receive it. A request carries an 8-bit destination, a bit that selects physical or logical addressing, a 2-bit shorthand, the sender's agent index and a 3-bit delivery-mode code. The block compares the request against per-agent registers held elsewhere in the chip: a physical ID, an 8-bit logical destination and a 4-bit format model. It then returns an N-bit mask with one bit per agent.

Shorthands override the destination field. They can address the sender alone, every agent, or every agent except the sender. Agents flagged as absent never receive anything. The delivery mode can narrow the result further. Lowest-priority delivery keeps only the lowest-indexed agent of the mask. The one reserved code delivers to nobody. The result is registered, and a valid pulse marks the cycle that follows each request strobe.

Top module: `irq_target_mask`

## Requirements
- R1: While reset is high and in the first cycle after it, `out_valid` is 0 and `out_mask` and `out_lowpri` are all zeros.
- R2: A request sampled with `req_valid` high on a rising edge makes `out_valid` 1 for exactly the following cycle, and `out_mask` shows that request's result in the same cycle. Without a request, `out_valid` is 0 and `out_mask` holds its last value. Back-to-back requests give back-to-back results.
- R3: With shorthand 0 and `req_logical` = 0 (physical), destination 8'hFF selects every agent. Any other destination selects the agents whose physical ID equals it, which may be none.
- R4: With shorthand 0 and `req_logical` = 1, an agent whose model is 4'hF (flat) matches when the bitwise AND of the destination and its logical destination is nonzero.
- R5: With shorthand 0 and `req_logical` = 1, an agent whose model is 4'h0 (cluster) matches when bits [7:4] of the destination equal bits [7:4] of its logical destination and the AND of bits [3:0] is nonzero. Any model other than 4'hF or 4'h0 never matches logically.
- R6: Shorthand 1 selects only the agent numbered `req_sender`. Shorthand 2 selects every agent. Shorthand 3 selects every agent except the sender. For shorthands 1 to 3, the destination and `req_logical` have no effect.
- R7: A bit whose `agent_present` bit is 0 is never set in a result. This holds for broadcast and shorthand requests too.
- R8: Delivery-mode code 3'd1 (lowest priority) reduces the mask to its lowest-indexed set bit and sets `out_lowpri` for that result. Every other code clears `out_lowpri`.
- R9: Codes 3'd0 (fixed), 3'd2 (SMI), 3'd4 (NMI), 3'd5 (INIT), 3'd6 (startup) and 3'd7 (external) pass the full mask. The reserved code 3'd3 yields an all-zero mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_dest | input | 8 | Destination field |
| req_logical | input | 1 | 0 = physical, 1 = logical addressing |
| req_shorthand | input | 2 | 0 none, 1 self, 2 all, 3 all but self |
| req_sender | input | IDX_W | Index of the sending agent |
| req_dmode | input | 3 | Delivery-mode code |
| agent_present | input | N | One bit per agent, 1 = agent exists |
| agent_phys_id | input | 8*N | Physical IDs, agent i at bits [8i+7:8i] |
| agent_log_dest | input | 8*N | Logical destinations, agent i at bits [8i+7:8i] |
| agent_model | input | 4*N | Format models, agent i at bits [4i+3:4i] |
| out_valid | output | 1 | Result valid, one cycle after a request |
| out_mask | output | N | Registered target mask |
| out_lowpri | output | 1 | Result came from lowest-priority reduction |

## Verification
Two functions can shape the same result in one cycle. The first is the shorthand override, including its exclusion of the sender. The second is the lowest-priority reduction, which works on whatever mask the override left. The sweep drives every pairing of shorthand and delivery code against every destination. One such case is the all-but-self shorthand with the sender at index 0, where the lowest-priority pick must skip to the next present agent. An arithmetic model in the bench judges each result. The same sweep also pairs presence gating with broadcast, so an absent low-numbered agent must never be the lowest-priority pick.

// File: rtl/irq_tgt_pkg.sv
package irq_tgt_pkg;

    localparam int DEST_W  = 8;
    localparam int MODEL_W = 4;
    localparam int NIB_W   = DEST_W / 2;

    localparam logic [DEST_W-1:0]  DEST_BCAST    = '1;
    localparam logic [MODEL_W-1:0] MODEL_FLAT    = 4'hF;
    localparam logic [MODEL_W-1:0] MODEL_CLUSTER = 4'h0;

    typedef enum logic [2:0] {
        DM_FIXED   = 3'd0,
        DM_LOWEST  = 3'd1,
        DM_SMI     = 3'd2,
        DM_RSVD    = 3'd3,
        DM_NMI     = 3'd4,
        DM_INIT    = 3'd5,
        DM_STARTUP = 3'd6,
        DM_EXTINT  = 3'd7
    } dlv_mode_e;

    typedef enum logic [1:0] {
        SH_NONE   = 2'd0,
        SH_SELF   = 2'd1,
        SH_ALL    = 2'd2,
        SH_OTHERS = 2'd3
    } shorthand_e;

    typedef struct packed {
        logic [DEST_W-1:0] dest;
        logic              logical;
        shorthand_e        sh;
        dlv_mode_e         mode;
    } req_fields_t;

    // flat model: any common bit
    function automatic logic flat_hit(input logic [DEST_W-1:0] dest,
                                      input logic [DEST_W-1:0] ldest);
        return |(dest & ldest);
    endfunction

    // cluster model: equal upper nibble, common bit in lower nibble
    function automatic logic cluster_hit(input logic [DEST_W-1:0] dest,
                                         input logic [DEST_W-1:0] ldest);
        logic same_cluster;
        logic member;
        same_cluster = (dest[DEST_W-1:NIB_W] == ldest[DEST_W-1:NIB_W]);
        member       = |(dest[NIB_W-1:0] & ldest[NIB_W-1:0]);
        return same_cluster && member;
    endfunction

    function automatic logic logical_hit(input logic [DEST_W-1:0]  dest,
                                         input logic [DEST_W-1:0]  ldest,
                                         input logic [MODEL_W-1:0] model);
        logic r;
        case (model)
            MODEL_FLAT:    r = flat_hit(dest, ldest);
            MODEL_CLUSTER: r = cluster_hit(dest, ldest);
            default:       r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/irq_tgt_agent_match.sv
module irq_tgt_agent_match
    import irq_tgt_pkg::*;
(
    input  logic [DEST_W-1:0]  dest_i,
    input  logic               logical_i,
    input  logic [DEST_W-1:0]  phys_id_i,
    input  logic [DEST_W-1:0]  log_dest_i,
    input  logic [MODEL_W-1:0] model_i,
    output logic               hit_o
);

    logic phys_hit;
    logic log_hit;

    always_comb begin
        phys_hit = (dest_i == DEST_BCAST) || (dest_i == phys_id_i);
        log_hit  = logical_hit(dest_i, log_dest_i, model_i);
        hit_o    = logical_i ? log_hit : phys_hit;
    end

endmodule

// File: rtl/irq_tgt_route.sv
module irq_tgt_route
    import irq_tgt_pkg::*;
#(
    parameter int N = 32,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
)(
    input  shorthand_e       sh_i,
    input  logic [IDX_W-1:0] sender_i,
    input  logic [N-1:0]     dest_hit_i,
    input  logic [N-1:0]     present_i,
    output logic [N-1:0]     mask_o
);

    logic [N-1:0] is_sender;
    logic [N-1:0] raw;

    for (genvar g = 0; g < N; g++) begin : g_self
        assign is_sender[g] = (sender_i == IDX_W'(g));
    end

    always_comb begin
        case (sh_i)
            SH_SELF:   raw = is_sender;
            SH_ALL:    raw = '1;
            SH_OTHERS: raw = ~is_sender;
            default:   raw = dest_hit_i;
        endcase
        mask_o = raw & present_i;
    end

endmodule

// File: rtl/irq_tgt_lowest.sv
module irq_tgt_lowest #(
    parameter int N = 32
)(
    input  logic [N-1:0] mask_i,
    output logic [N-1:0] first_o
);

    localparam logic [N-1:0] ONE = {{(N-1){1'b0}}, 1'b1};

    // two's complement isolates the least significant set bit
    assign first_o = mask_i & (~mask_i + ONE);

endmodule

// File: rtl/irq_target_mask.sv
module irq_target_mask
    import irq_tgt_pkg::*;
#(
    parameter int N = 32,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
)(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic [7:0]           req_dest,
    input  logic                 req_logical,
    input  logic [1:0]           req_shorthand,
    input  logic [IDX_W-1:0]     req_sender,
    input  logic [2:0]           req_dmode,
    input  logic [N-1:0]         agent_present,
    input  logic [N*8-1:0]       agent_phys_id,
    input  logic [N*8-1:0]       agent_log_dest,
    input  logic [N*4-1:0]       agent_model,
    output logic                 out_valid,
    output logic [N-1:0]         out_mask,
    output logic                 out_lowpri
);

    req_fields_t  req;
    logic [N-1:0] dest_hit;
    logic [N-1:0] routed;
    logic [N-1:0] first_hit;
    logic [N-1:0] next_mask;
    logic         next_lowpri;

    always_comb begin
        req.dest    = req_dest;
        req.logical = req_logical;
        req.sh      = shorthand_e'(req_shorthand);
        req.mode    = dlv_mode_e'(req_dmode);
    end

    for (genvar g = 0; g < N; g++) begin : g_agent
        irq_tgt_agent_match u_match (
            .dest_i     (req.dest),
            .logical_i  (req.logical),
            .phys_id_i  (agent_phys_id[g*DEST_W +: DEST_W]),
            .log_dest_i (agent_log_dest[g*DEST_W +: DEST_W]),
            .model_i    (agent_model[g*MODEL_W +: MODEL_W]),
            .hit_o      (dest_hit[g])
        );
    end

    irq_tgt_route #(.N(N)) u_route (
        .sh_i       (req.sh),
        .sender_i   (req_sender),
        .dest_hit_i (dest_hit),
        .present_i  (agent_present),
        .mask_o     (routed)
    );

    irq_tgt_lowest #(.N(N)) u_lowest (
        .mask_i  (routed),
        .first_o (first_hit)
    );

    always_comb begin
        next_lowpri = 1'b0;
        case (req.mode)
            DM_RSVD:   next_mask = '0;
            DM_LOWEST: begin
                next_mask   = first_hit;
                next_lowpri = 1'b1;
            end
            default:   next_mask = routed;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_mask   <= '0;
            out_lowpri <= 1'b0;
        end else begin
            out_valid <= req_valid;
            if (req_valid) begin
                out_mask   <= next_mask;
                out_lowpri <= next_lowpri;
            end
        end
    end

endmodule

// File: rtl/irq_target_mask_chk.sv
module irq_target_mask_chk #(
    parameter int N = 32,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
)(
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic [1:0]       req_shorthand,
    input logic [IDX_W-1:0] req_sender,
    input logic [2:0]       req_dmode,
    input logic [N-1:0]     agent_present,
    input logic             out_valid,
    input logic [N-1:0]     out_mask,
    input logic             out_lowpri
);

    logic [N-1:0] sender_bit;
    assign sender_bit = {{(N-1){1'b0}}, 1'b1} << req_sender;

    AST_VALID_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> out_valid); // R2
    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !out_valid); // R2
    AST_MASK_HELD: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> $stable(out_mask)); // R2
    AST_ONLY_PRESENT: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> ((out_mask & ~$past(agent_present)) == '0)); // R7
    AST_SELF_ONLY: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_shorthand == 2'd1) |=> ((out_mask & ~$past(sender_bit)) == '0)); // R6
    AST_OTHERS_SKIP_SENDER: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_shorthand == 2'd3) |=> ((out_mask & $past(sender_bit)) == '0)); // R6
    AST_LOWEST_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_dmode == 3'd1) |=> ($onehot0(out_mask) && out_lowpri)); // R8
    AST_LOWPRI_FLAG_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_dmode != 3'd1) |=> !out_lowpri); // R8
    AST_RESERVED_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_dmode == 3'd3) |=> ($countones(out_mask) == 0)); // R9

endmodule

bind irq_target_mask irq_target_mask_chk #(.N(N)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .req_shorthand (req_shorthand),
    .req_sender    (req_sender),
    .req_dmode     (req_dmode),
    .agent_present (agent_present),
    .out_valid     (out_valid),
    .out_mask      (out_mask),
    .out_lowpri    (out_lowpri)
);

// File: tb/irq_target_mask_bench.sv
module irq_target_mask_bench;

    localparam int N     = 8;
    localparam int IDX_W = 3;
    localparam int WD_CYCLES = 150000;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             req_valid = 1'b0;
    logic [7:0]       req_dest = '0;
    logic             req_logical = 1'b0;
    logic [1:0]       req_shorthand = '0;
    logic [IDX_W-1:0] req_sender = '0;
    logic [2:0]       req_dmode = '0;
    logic [N-1:0]     agent_present;
    logic [N*8-1:0]   agent_phys_id;
    logic [N*8-1:0]   agent_log_dest;
    logic [N*4-1:0]   agent_model;
    logic             out_valid;
    logic [N-1:0]     out_mask;
    logic             out_lowpri;

    logic [N-1:0] pres;
    logic [7:0]   pid  [N];
    logic [7:0]   ldst [N];
    logic [3:0]   mdl  [N];

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    always_comb begin
        agent_present = pres;
        for (int i = 0; i < N; i++) begin
            agent_phys_id[i*8 +: 8]  = pid[i];
            agent_log_dest[i*8 +: 8] = ldst[i];
            agent_model[i*4 +: 4]    = mdl[i];
        end
    end

    irq_target_mask #(.N(N)) u_irq_target_mask (
        .clk            (clk),
        .rst            (rst),
        .req_valid      (req_valid),
        .req_dest       (req_dest),
        .req_logical    (req_logical),
        .req_shorthand  (req_shorthand),
        .req_sender     (req_sender),
        .req_dmode      (req_dmode),
        .agent_present  (agent_present),
        .agent_phys_id  (agent_phys_id),
        .agent_log_dest (agent_log_dest),
        .agent_model    (agent_model),
        .out_valid      (out_valid),
        .out_mask       (out_mask),
        .out_lowpri     (out_lowpri)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    // reference built from the requirement text
    function automatic logic [N-1:0] ref_mask(input logic [7:0] d, input logic lg,
                                              input logic [1:0] sh, input int snd,
                                              input logic [2:0] dm);
        logic [N-1:0] m;
        logic [N-1:0] low;
        bit found;
        for (int i = 0; i < N; i++) begin
            logic h;
            case (sh)
                2'd1: h = (i == snd);
                2'd2: h = 1'b1;
                2'd3: h = (i != snd);
                default: begin
                    if (!lg)                h = (d == 8'hFF) || (pid[i] == d);
                    else if (mdl[i] == 4'hF) h = (d & ldst[i]) != 8'h00;
                    else if (mdl[i] == 4'h0) h = (d[7:4] == ldst[i][7:4]) &&
                                                 ((d[3:0] & ldst[i][3:0]) != 4'h0);
                    else                     h = 1'b0;
                end
            endcase
            m[i] = h && pres[i];
        end
        if (dm == 3'd3) return '0;
        if (dm == 3'd1) begin
            low = '0;
            found = 1'b0;
            for (int i = 0; i < N; i++) begin
                if (m[i] && !found) begin
                    low[i] = 1'b1;
                    found = 1'b1;
                end
            end
            return low;
        end
        return m;
    endfunction

    task automatic set_cfg(input int c);
        for (int i = 0; i < N; i++) begin
            case (c)
                0: begin
                    pid[i]  = 8'(i * 3 + 1);
                    ldst[i] = 8'(1 << i);
                    mdl[i]  = 4'hF;
                end
                1: begin
                    pid[i]  = 8'(8'h10 + i);
                    ldst[i] = {4'((i >> 2) + 1), 4'(1 << (i & 3))};
                    mdl[i]  = (i == 5) ? 4'h7 : 4'h0;
                end
                default: begin
                    pid[i]  = 8'(8'hF0 + i * 2);
                    ldst[i] = 8'((i * 37 + 11) & 8'hFF);
                    mdl[i]  = (i % 2 == 0) ? 4'hF : 4'h0;
                end
            endcase
        end
        case (c)
            0:       pres = 8'hFF;
            1:       pres = 8'b1011_0110;
            default: pres = 8'hFE;
        endcase
    endtask

    function automatic string tag_of(input int c, input logic lg,
                                     input logic [1:0] sh, input logic [2:0] dm);
        if (dm == 3'd3) return "R9";
        if (dm == 3'd1) return "R8";
        if (sh != 2'd0) return "R6";
        if (!lg)        return "R3";
        if (c == 0)     return "R4";
        return "R5";
    endfunction

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R2 watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [N-1:0] held;
        set_cfg(0);
        repeat (3) @(negedge clk);
        // R1: outputs cleared while in reset
        chk("R1", "valid in reset", 32'(out_valid), 32'd0);
        chk("R1", "mask in reset", 32'(out_mask), 32'd0);
        chk("R1", "lowpri in reset", 32'(out_lowpri), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "valid after reset", 32'(out_valid), 32'd0);
        chk("R1", "mask after reset", 32'(out_mask), 32'd0);

        for (int c = 0; c < 3; c++) begin
            set_cfg(c);
            for (int d = 0; d < 256; d++) begin
                for (int lg = 0; lg < 2; lg++) begin
                    for (int sh = 0; sh < 4; sh++) begin
                        for (int dm = 0; dm < 8; dm++) begin
                            logic [N-1:0] exp;
                            int snd;
                            string tg;
                            snd = (d + sh) % N;
                            req_valid     = 1'b1;
                            req_dest      = 8'(d);
                            req_logical   = 1'(lg);
                            req_shorthand = 2'(sh);
                            req_sender    = IDX_W'(snd);
                            req_dmode     = 3'(dm);
                            exp = ref_mask(8'(d), 1'(lg), 2'(sh), snd, 3'(dm));
                            tg  = tag_of(c, 1'(lg), 2'(sh), 3'(dm));
                            @(negedge clk);
                            chk("R2", "valid after request", 32'(out_valid), 32'd1);
                            chk(tg, "mask", 32'(out_mask), 32'(exp));
                            chk("R8", "lowpri flag", 32'(out_lowpri), 32'(dm == 1));
                            chk("R7", "absent agents", 32'(out_mask & ~pres), 32'd0);
                        end
                    end
                end
            end
        end

        // R2: idle cycles drop valid and hold the mask
        req_valid = 1'b0;
        held = out_mask;
        req_dest = 8'hFF;
        req_shorthand = 2'd2;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R2", "valid when idle", 32'(out_valid), 32'd0);
            chk("R2", "mask held when idle", 32'(out_mask), 32'(held));
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule